// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Engine

This block keeps an asynchronous DRAM alive and brings it up after reset. When reset is released, it waits through a programmable power-up pause. It then runs a fixed burst of warm-up refresh cycles and only after that reports the memory ready. From then on an interval timer posts refresh requests at a steady rate. Each request is held until the access sequencer grants it. If grants are late, a small saturating backlog records the missed requests.

Every refresh is a CAS-before-RAS cycle built from clock-counted phases. The column strobe falls first. The row strobe then falls while the column strobe is still low. The column strobe rises before the row strobe, and a precharge phase closes the cycle. The write enable is kept high throughout, so the device never sees a test-mode cycle. A busy output covers the whole cycle so that the sequencer stays off the bus.

Top module: `dram_refresh_engine`

## Requirements
- R1: `mem_ready` is 0 in reset and after reset until the warm-up burst ends. It first reads 1 after exactly INIT_CYC + WARMUP·(CSR_CYC+RAS_CYC+PRE_CYC+1) rising edges counted from reset release, and never drops again.
- R2: No strobe moves during the pause. The first refresh cycle starts at edge INIT_CYC+1, and exactly WARMUP refresh cycles run before `mem_ready` rises, with `ref_gnt` held low.
- R3: In every refresh cycle `cas_n` is low for exactly CSR_CYC cycles before `ras_n` falls. It stays low for exactly CHR_CYC cycles with `ras_n` low.
- R4: `ras_n` stays low for exactly RAS_CYC cycles. Between refresh cycles it stays high for at least PRE_CYC+CSR_CYC cycles.
- R5: `we_n` is 1 at all times.
- R6: Once ready, the first pending request (`ref_req`=1) appears exactly INTERVAL edges after the edge that set `mem_ready`. Further requests follow every INTERVAL edges.
- R7: A pending request stays asserted until it is served. A refresh starts only in a cycle where `ref_req`, `ref_gnt` and `seq_idle` are all 1, and that start retires one pending request.
- R8: The backlog saturates at BACKLOG_MAX. After more than BACKLOG_MAX ungranted intervals, a continuous grant yields exactly BACKLOG_MAX refresh cycles and then `ref_req` returns to 0.
- R9: `ref_busy` is 1 whenever `ras_n` or `cas_n` is low. It rises one edge after a granted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_idle | input | 1 | Access sequencer idle with its row strobe high |
| ref_gnt | input | 1 | Grant from the access sequencer |
| ref_req | output | 1 | At least one refresh pending |
| ref_busy | output | 1 | Refresh cycle in progress; blocks accesses |
| mem_ready | output | 1 | Initialisation complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The hardest state to reach from the ports is a saturated backlog, with requests piled up behind a sequencer that never grants. The bench computes the edge at which each interval tick lands from the measured ready edge. It withholds the grant for more ticks than the backlog can hold. It then opens the grant just after a tick and drains, so that no further tick falls inside the drain window, and counts the row-strobe falls.

// File: rtl/drfe_pkg.sv
package drfe_pkg;

    typedef enum logic [2:0] {
        G_IDLE,
        G_CSR,
        G_CHR,
        G_HOLD,
        G_PRE
    } gen_st_t;

    typedef enum logic [1:0] {
        I_PAUSE,
        I_WARM,
        I_RUN
    } init_st_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    // Bits needed to hold values 0 .. n-1
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/drfe_interval.sv
module drfe_interval #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    import drfe_pkg::*;

    localparam int TW = cnt_w(INTERVAL);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en)       cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/drfe_backlog.sv
module drfe_backlog #(
    parameter int BACKLOG_MAX = 4,
    localparam int PW = drfe_pkg::cnt_w(BACKLOG_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [PW-1:0] pend,
    output logic          pend_nz
);
    localparam logic [PW-1:0] FULL = PW'(BACKLOG_MAX);

    logic [PW-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (pend_q != FULL) pend_q <= pend_q + 1'b1;
                2'b01:   if (pend_q != '0)   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign pend    = pend_q;
    assign pend_nz = (pend_q != '0);
endmodule

// File: rtl/drfe_cbr_gen.sv
module drfe_cbr_gen #(
    parameter int CSR_CYC = 1,
    parameter int CHR_CYC = 1,
    parameter int RAS_CYC = 5,
    parameter int PRE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output drfe_pkg::strobe_t strb,
    output logic              busy,
    output logic              done
);
    import drfe_pkg::*;

    // The row strobe stays low for CHR_CYC + HOLD_CYC = RAS_CYC cycles.
    localparam int HOLD_CYC = RAS_CYC - CHR_CYC;
    localparam int PW = cnt_w(max4(CSR_CYC, CHR_CYC, HOLD_CYC, PRE_CYC));
    localparam logic [PW-1:0] L_CSR  = PW'(CSR_CYC - 1);
    localparam logic [PW-1:0] L_CHR  = PW'(CHR_CYC - 1);
    localparam logic [PW-1:0] L_HOLD = PW'(HOLD_CYC - 1);
    localparam logic [PW-1:0] L_PRE  = PW'(PRE_CYC - 1);

    gen_st_t       st_q, st_d;
    logic [PW-1:0] ph_q;
    logic [PW-1:0] last;
    logic          ph_end;

    always_comb begin
        unique case (st_q)
            G_CSR:   last = L_CSR;
            G_CHR:   last = L_CHR;
            G_HOLD:  last = L_HOLD;
            G_PRE:   last = L_PRE;
            default: last = '0;
        endcase
    end

    assign ph_end = (ph_q == last);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            G_IDLE:  if (start)  st_d = G_CSR;
            G_CSR:   if (ph_end) st_d = G_CHR;
            G_CHR:   if (ph_end) st_d = G_HOLD;
            G_HOLD:  if (ph_end) st_d = G_PRE;
            G_PRE:   if (ph_end) st_d = G_IDLE;
            default: st_d = G_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= G_IDLE;
            ph_q <= '0;
        end else begin
            st_q <= st_d;
            ph_q <= (st_d != st_q) ? '0 : ph_q + 1'b1;
        end
    end

    assign strb.cas_n = !(st_q == G_CSR || st_q == G_CHR);
    assign strb.ras_n = !(st_q == G_CHR || st_q == G_HOLD);
    assign busy       = (st_q != G_IDLE);
    assign done       = (st_q == G_PRE) && ph_end;
endmodule

// File: rtl/dram_refresh_engine.sv
module dram_refresh_engine #(
    parameter int INIT_CYC    = 20000,
    parameter int WARMUP      = 8,
    parameter int INTERVAL    = 1560,
    parameter int BACKLOG_MAX = 4,
    parameter int CSR_CYC     = 1,
    parameter int CHR_CYC     = 1,
    parameter int RAS_CYC     = 5,
    parameter int PRE_CYC     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic seq_idle,
    input  logic ref_gnt,
    output logic ref_req,
    output logic ref_busy,
    output logic mem_ready,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    import drfe_pkg::*;

    localparam int IW = cnt_w(INIT_CYC);
    localparam int WW = cnt_w(WARMUP + 1);
    localparam int PEND_W = cnt_w(BACKLOG_MAX + 1);
    localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYC - 1);
    localparam logic [WW-1:0] WARM_LAST = WW'(WARMUP - 1);

    init_st_t      ist_q;
    logic [IW-1:0] pause_q;
    logic [WW-1:0] warm_q;

    logic          gen_busy, gen_done, start, tick, pend_nz;
    logic [PEND_W-1:0] pend_cnt;
    strobe_t       strb;

    // Warm-up cycles need no grant: no access can run before ready.
    assign start = !gen_busy &&
                   ((ist_q == I_WARM) ||
                    (ist_q == I_RUN && pend_nz && ref_gnt && seq_idle));

    always_ff @(posedge clk) begin
        if (rst) begin
            ist_q   <= I_PAUSE;
            pause_q <= '0;
            warm_q  <= '0;
        end else begin
            unique case (ist_q)
                I_PAUSE: begin
                    if (pause_q == INIT_LAST) ist_q <= I_WARM;
                    else                      pause_q <= pause_q + 1'b1;
                end
                I_WARM: begin
                    if (gen_done) begin
                        warm_q <= warm_q + 1'b1;
                        if (warm_q == WARM_LAST) ist_q <= I_RUN;
                    end
                end
                default: ist_q <= I_RUN;
            endcase
        end
    end

    drfe_interval #(.INTERVAL(INTERVAL)) u_interval (
        .clk  (clk),
        .rst  (rst),
        .en   (ist_q == I_RUN),
        .tick (tick)
    );

    drfe_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) u_backlog (
        .clk     (clk),
        .rst     (rst),
        .inc     (tick),
        .dec     (start && ist_q == I_RUN),
        .pend    (pend_cnt),
        .pend_nz (pend_nz)
    );

    drfe_cbr_gen #(
        .CSR_CYC (CSR_CYC),
        .CHR_CYC (CHR_CYC),
        .RAS_CYC (RAS_CYC),
        .PRE_CYC (PRE_CYC)
    ) u_gen (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .strb  (strb),
        .busy  (gen_busy),
        .done  (gen_done)
    );

    assign ref_req   = (ist_q == I_RUN) && pend_nz;
    assign ref_busy  = gen_busy;
    assign mem_ready = (ist_q == I_RUN);
    assign ras_n     = strb.ras_n;
    assign cas_n     = strb.cas_n;
    assign we_n      = 1'b1;
endmodule

// File: rtl/drfe_checker.sv
module drfe_checker #(
    parameter int PEND_W      = 3,
    parameter int BACKLOG_MAX = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ras_n,
    input logic              cas_n,
    input logic              ref_busy,
    input logic              mem_ready,
    input logic              ref_req,
    input logic              ref_gnt,
    input logic              seq_idle,
    input logic [PEND_W-1:0] pend
);
    assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    assert_cas_up_first_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> cas_n);

    assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        mem_ready |=> mem_ready);

    assert_start_granted_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(ref_busy) && mem_ready) |-> $past(ref_gnt && seq_idle && ref_req));

    assert_backlog_bound_R8: assert property (@(posedge clk) disable iff (rst)
        int'(pend) <= BACKLOG_MAX);

    assert_busy_cover_R9: assert property (@(posedge clk) disable iff (rst)
        (!ras_n || !cas_n) |-> ref_busy);
endmodule

bind dram_refresh_engine drfe_checker #(
    .PEND_W      (PEND_W),
    .BACKLOG_MAX (BACKLOG_MAX)
) u_drfe_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .ref_busy  (ref_busy),
    .mem_ready (mem_ready),
    .ref_req   (ref_req),
    .ref_gnt   (ref_gnt),
    .seq_idle  (seq_idle),
    .pend      (pend_cnt)
);

// File: tb/dram_refresh_engine_bench.sv
`timescale 1ns/1ps
module dram_refresh_engine_bench;
    localparam int INIT_CYC = 20;
    localparam int WARMUP   = 8;
    localparam int INTERVAL = 60;
    localparam int BMAX     = 3;
    localparam int CSR      = 1;
    localparam int CHR      = 2;
    localparam int RAS      = 4;
    localparam int PRE      = 3;
    localparam int TCYC     = CSR + RAS + PRE;
    localparam int READY_EXP = INIT_CYC + WARMUP * (TCYC + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic seq_idle = 1'b1;
    logic ref_gnt = 1'b0;
    logic ref_req, ref_busy, mem_ready, ras_n, cas_n, we_n;

    always #5 clk = ~clk;

    dram_refresh_engine #(
        .INIT_CYC (INIT_CYC), .WARMUP (WARMUP), .INTERVAL (INTERVAL),
        .BACKLOG_MAX (BMAX), .CSR_CYC (CSR), .CHR_CYC (CHR),
        .RAS_CYC (RAS), .PRE_CYC (PRE)
    ) u_dram_refresh_engine (
        .clk (clk), .rst (rst), .seq_idle (seq_idle), .ref_gnt (ref_gnt),
        .ref_req (ref_req), .ref_busy (ref_busy), .mem_ready (mem_ready),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n)
    );

    int total = 0;
    int bad = 0;
    int edge_cnt = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) edge_cnt <= 0;
        else     edge_cnt <= edge_cnt + 1;
    end

    // Strobe monitor, sampled mid-cycle
    int  falls = 0;
    int  first_cas_edge = -1;
    int  ready_edge = -1;
    int  cas_low_run = 0, both_low_run = 0, ras_low_run = 0, ras_high_run = 1000;
    int  we_bad = 0, busy_bad = 0, ready_drop = 0;
    bit  prev_ras = 1'b1, prev_cas = 1'b1, prev_ready = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!we_n) we_bad++;
            if ((!ras_n || !cas_n) && !ref_busy) busy_bad++;
            if (prev_ready && !mem_ready) ready_drop++;
            if (mem_ready && !prev_ready && ready_edge < 0) ready_edge = edge_cnt;
            if (!cas_n && prev_cas && first_cas_edge < 0) first_cas_edge = edge_cnt;
            if (!ras_n && prev_ras) begin
                falls++;
                check(cas_low_run == CSR, "R3 cas lead", cas_low_run, CSR);
                check(ras_high_run >= PRE + CSR, "R4 precharge", ras_high_run, PRE + CSR);
            end
            if (ras_n && !prev_ras)
                check(ras_low_run == RAS, "R4 ras width", ras_low_run, RAS);
            if (cas_n && !prev_cas && !ras_n)
                check(both_low_run == CHR, "R3 cas hold", both_low_run, CHR);
            cas_low_run  = (!cas_n && ras_n) ? cas_low_run + 1 : (cas_n ? 0 : cas_low_run);
            both_low_run = (!cas_n && !ras_n) ? both_low_run + 1 : 0;
            ras_low_run  = !ras_n ? ras_low_run + 1 : 0;
            ras_high_run = ras_n ? ras_high_run + 1 : 0;
            prev_ras = ras_n; prev_cas = cas_n; prev_ready = mem_ready;
        end
    end

    task automatic wait_edge(input int k);
        while (edge_cnt < k) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // Reset state (R1)
        check(mem_ready == 0, "R1 reset ready", mem_ready, 0);
        check(ref_req == 0, "R7 reset req", ref_req, 0);
        check(ras_n && cas_n, "R2 reset strobes", {ras_n, cas_n}, 3);
        check(ref_busy == 0, "R9 reset busy", ref_busy, 0);
        rst = 1'b0;

        wait_edge(READY_EXP + 2);
        check(ready_edge == READY_EXP, "R1 ready edge", ready_edge, READY_EXP);
        check(first_cas_edge == INIT_CYC + 1, "R2 first cycle edge", first_cas_edge, INIT_CYC + 1);
        check(falls == WARMUP, "R2 warm-up count", falls, WARMUP);

        // R6: first request after one interval
        wait_edge(ready_edge + INTERVAL - 1);
        check(ref_req == 0, "R6 before tick", ref_req, 0);
        @(negedge clk);
        check(ref_req == 1, "R6 at tick", ref_req, 1);

        // R7: grant without idle, then idle without grant
        begin
            int f0;
            f0 = falls;
            ref_gnt = 1'b1; seq_idle = 1'b0;
            repeat (20) @(negedge clk);
            check(falls == f0, "R7 no start when busy seq", falls, f0);
            check(ref_req == 1, "R7 req held", ref_req, 1);
            ref_gnt = 1'b0; seq_idle = 1'b1;
            repeat (10) @(negedge clk);
            check(falls == f0, "R7 no start without grant", falls, f0);
            ref_gnt = 1'b1;
            @(negedge clk);
            check(ref_busy == 1, "R9 busy after grant", ref_busy, 1);
            repeat (TCYC + 1) @(negedge clk);
            ref_gnt = 1'b0;
            check(falls == f0 + 1, "R7 one refresh served", falls, f0 + 1);
            check(ref_req == 0, "R7 req retired", ref_req, 0);
            check(ref_busy == 0, "R9 busy ends", ref_busy, 0);
        end

        // R8: saturation after five ungranted intervals
        wait_edge(ready_edge + 6 * INTERVAL + 5);
        check(ref_req == 1, "R8 pending", ref_req, 1);
        begin
            int f1;
            f1 = falls;
            ref_gnt = 1'b1;
            repeat (40) @(negedge clk);
            ref_gnt = 1'b0;
            check(falls - f1 == BMAX, "R8 drained count", falls - f1, BMAX);
            check(ref_req == 0, "R8 drained", ref_req, 0);
        end

        check(we_bad == 0, "R5 we high", we_bad, 0);
        check(busy_bad == 0, "R9 busy cover", busy_bad, 0);
        check(ready_drop == 0, "R1 ready sticky", ready_drop, 0);
        check(mem_ready == 1, "R1 ready held", mem_ready, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog", edge_cnt, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule